// File: doc/BRIEF.md
# Multiplexed Pin Bank Controller with Input Deglitching

This block manages a bank of general purpose pins. Each pin is either driven by the controller, which sets its direction and output level, or handed to an on-chip peripheral that supplies its own output value and output enable. Two copies of the block can be placed side by side to serve a larger set of lines, for example one with 12 pins and one with 11 pins for 23 lines.

Every pad input passes through a two-flop synchronizer. A per-pin deglitch stage can then be switched in. It accepts a new level only after two consecutive equal samples, so pulses shorter than two clock cycles are rejected. Any change of the resulting level sets a sticky event bit. The interrupt output is raised while any event bit whose enable bit is set is pending.

Software uses a small register port. Ownership, direction, output level, filter enable and interrupt enable each have a "set" address and a "clear" address, so single bits can be changed without a read-modify-write. The pin level and the event status can be read. Reading the event status clears the bits it returned.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset, every pin is owned by the peripheral, every control register (ownership, direction, output, filter, interrupt enable) reads 0, no event is pending and `irq` is 0.
- R2: On a pin whose ownership bit is 0, `pad_out` and `pad_oe` follow `per_out` and `per_oe` one cycle later.
- R3: A write to a set address (ownership 0x0, direction 0x2, output 0x4, filter 0x6, interrupt enable 0x8) ORs `wdata` into that register. A write to the matching clear address (0x1, 0x3, 0x5, 0x7, 0x9) clears the bits set in `wdata`. Other bits are unchanged. A read of a set address returns the register.
- R4: On a pin whose ownership bit is 1, `pad_oe` equals its direction bit (1 = output) and `pad_out` equals its output bit, one cycle after the register changes.
- R5: A read of address 0xA returns the synchronized pin levels. After a pad change, the new level can be read once the synchronizer has settled (three clock edges).
- R6: With filter enabled on a pin, a pad pulse lasting one clock cycle changes neither the pin level nor the event status.
- R7: With filter enabled, a pad level held for two or more cycles is accepted and produces an event.
- R8: Each change of a pin level, rising or falling, sets that pin's event bit, which stays set until it is read.
- R9: A read of address 0xB returns the event bits and clears the bits it returned. A second read returns 0 if no new change has occurred.
- R10: `irq` is 1 exactly one cycle after some event bit is set whose interrupt enable bit is also set. Pending events on pins with interrupt disabled do not raise it.
- R11: With the filter disabled, a one-cycle pad pulse is recorded as an event.
- R12: Writes to the read-only addresses 0xA and 0xB change no control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | NUM_PINS | Write data, one bit per pin |
| rdata | output | NUM_PINS | Read data, valid the cycle after `rd_en` |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_out | output | NUM_PINS | Pad output value (registered) |
| pad_oe | output | NUM_PINS | Pad output enable (registered) |
| per_out | input | NUM_PINS | Peripheral output values |
| per_oe | input | NUM_PINS | Peripheral output enables |
| irq | output | 1 | Level interrupt request (registered) |

## Verification
The bound checker watches the following rules on every cycle: the registered pad multiplexer, the set and clear arithmetic on the ownership register, the stickiness of event bits outside status reads, the value returned by a status read, the interrupt as a registered function of pending and enabled events, and the reset values. The deglitch behaviour can only be shown by the bench's pulse scenarios, because it depends on pad pulses of chosen lengths: a one-cycle pulse must be rejected when the filter is on and recorded when it is off. The same holds for the latency from pad to readable level and for the clear-on-read sequence across two reads.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_OWN_SET = 4'h0,
    A_OWN_CLR = 4'h1,
    A_DIR_SET = 4'h2,
    A_DIR_CLR = 4'h3,
    A_OUT_SET = 4'h4,
    A_OUT_CLR = 4'h5,
    A_FLT_SET = 4'h6,
    A_FLT_CLR = 4'h7,
    A_IEN_SET = 4'h8,
    A_IEN_CLR = 4'h9,
    A_PIN_LVL = 4'hA,
    A_EVT_STA = 4'hB
  } reg_addr_e;
endpackage

// File: rtl/pin_input_stage.sv
module pin_input_stage #(
  parameter int NUM_PINS = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] flt_en,
  output logic [NUM_PINS-1:0] lvl
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   lvl_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '0;
        prev_q <= 1'b0;
        lvl_q  <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in[i]};
        prev_q <= sync_q[LAST];
        // filtered path takes a value only after two equal samples
        if (!flt_en[i] || (sync_q[LAST] == prev_q))
          lvl_q <= sync_q[LAST];
      end
    end

    assign lvl[i] = lvl_q;
  end
endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit #(
  parameter int NUM_PINS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [NUM_PINS-1:0] ien,
  input  logic                evt_clr,
  output logic [NUM_PINS-1:0] evt,
  output logic                irq
);
  logic [NUM_PINS-1:0] lvl_d;
  logic [NUM_PINS-1:0] evt_q;
  logic [NUM_PINS-1:0] chg;
  logic                irq_q;

  assign chg = lvl ^ lvl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d <= '0;
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      lvl_d <= lvl;
      // a change arriving on the clearing cycle survives the clear
      evt_q <= (evt_clr ? '0 : evt_q) | chg;
      irq_q <= |(evt_q & ien);
    end
  end

  assign evt = evt_q;
  assign irq = irq_q;
endmodule

// File: rtl/pin_ctrl_regs.sv
module pin_ctrl_regs
  import pin_bank_pkg::*;
#(
  parameter int NUM_PINS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [NUM_PINS-1:0] evt,
  output logic [NUM_PINS-1:0] own,
  output logic [NUM_PINS-1:0] dir,
  output logic [NUM_PINS-1:0] out,
  output logic [NUM_PINS-1:0] flt,
  output logic [NUM_PINS-1:0] ien,
  output logic [NUM_PINS-1:0] rdata,
  output logic                evt_clr
);
  localparam int NUM_CTRL = 5;

  logic [NUM_PINS-1:0] ctrl_q [NUM_CTRL];
  logic [NUM_PINS-1:0] rdata_q;

  for (genvar r = 0; r < NUM_CTRL; r++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(2 * r);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(2 * r + 1);
    always_ff @(posedge clk) begin
      if (rst)
        ctrl_q[r] <= '0;
      else if (wr_en && addr == SET_A)
        ctrl_q[r] <= ctrl_q[r] | wdata;
      else if (wr_en && addr == CLR_A)
        ctrl_q[r] <= ctrl_q[r] & ~wdata;
    end
  end

  assign own = ctrl_q[0];
  assign dir = ctrl_q[1];
  assign out = ctrl_q[2];
  assign flt = ctrl_q[3];
  assign ien = ctrl_q[4];

  assign evt_clr = rd_en && (addr == A_EVT_STA);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (addr)
        A_OWN_SET, A_OWN_CLR: rdata_q <= ctrl_q[0];
        A_DIR_SET, A_DIR_CLR: rdata_q <= ctrl_q[1];
        A_OUT_SET, A_OUT_CLR: rdata_q <= ctrl_q[2];
        A_FLT_SET, A_FLT_CLR: rdata_q <= ctrl_q[3];
        A_IEN_SET, A_IEN_CLR: rdata_q <= ctrl_q[4];
        A_PIN_LVL:            rdata_q <= lvl;
        A_EVT_STA:            rdata_q <= evt;
        default:              rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int NUM_PINS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] per_out,
  input  logic [NUM_PINS-1:0] per_oe,
  output logic                irq
);
  logic [NUM_PINS-1:0] own_q, dir_q, out_q, flt_q, ien_q;
  logic [NUM_PINS-1:0] lvl, evt_q;
  logic                evt_clr;
  logic [NUM_PINS-1:0] pad_out_q, pad_oe_q;

  pin_ctrl_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .lvl(lvl), .evt(evt_q),
    .own(own_q), .dir(dir_q), .out(out_q), .flt(flt_q), .ien(ien_q),
    .rdata(rdata), .evt_clr(evt_clr)
  );

  pin_input_stage #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(2)) u_inp (
    .clk(clk), .rst(rst), .pad_in(pad_in), .flt_en(flt_q), .lvl(lvl)
  );

  pin_event_unit #(.NUM_PINS(NUM_PINS)) u_evt (
    .clk(clk), .rst(rst), .lvl(lvl), .ien(ien_q), .evt_clr(evt_clr),
    .evt(evt_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out_q <= '0;
      pad_oe_q  <= '0;
    end else begin
      pad_out_q <= (own_q & out_q) | (~own_q & per_out);
      pad_oe_q  <= (own_q & dir_q) | (~own_q & per_oe);
    end
  end

  assign pad_out = pad_out_q;
  assign pad_oe  = pad_oe_q;
endmodule

// File: rtl/pin_bank_ctrl_chk.sv
module pin_bank_ctrl_chk
  import pin_bank_pkg::*;
#(
  parameter int NUM_PINS = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_PINS-1:0] wdata,
  input logic [NUM_PINS-1:0] rdata,
  input logic [NUM_PINS-1:0] per_out,
  input logic [NUM_PINS-1:0] per_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] own_q,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] out_q,
  input logic [NUM_PINS-1:0] ien_q,
  input logic [NUM_PINS-1:0] evt_q,
  input logic                irq
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (own_q == '0 && ien_q == '0 && evt_q == '0 && !irq));

  assert_pad_mux_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pad_oe == $past((own_q & dir_q) | (~own_q & per_oe)) &&
                    pad_out == $past((own_q & out_q) | (~own_q & per_out)));

  assert_own_set_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_OWN_SET) |=> own_q == ($past(own_q) | $past(wdata)));

  assert_own_clr_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_OWN_CLR) |=> own_q == ($past(own_q) & ~$past(wdata)));

  assert_evt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == A_EVT_STA) |=> (evt_q & $past(evt_q)) == $past(evt_q));

  assert_evt_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_EVT_STA) |=> rdata == $past(evt_q));

  assert_irq_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == |($past(evt_q) & $past(ien_q)));
endmodule

bind pin_bank_ctrl pin_bank_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .per_out(per_out), .per_oe(per_oe),
  .pad_out(pad_out), .pad_oe(pad_oe), .own_q(own_q), .dir_q(dir_q),
  .out_q(out_q), .ien_q(ien_q), .evt_q(evt_q), .irq(irq)
);

// File: tb/pin_bank_ctrl_tb.sv
module pin_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [3:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic [N-1:0] per_out = '0;
  logic [N-1:0] per_oe = '0;
  logic         irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_bank_ctrl #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    per_out = 12'hA5C; per_oe = 12'h3F0;
    idle(2);
    check("R1 pad_out from peripheral", 32'(pad_out), 32'(12'hA5C));
    check("R1 pad_oe from peripheral", 32'(pad_oe), 32'(12'h3F0));
    check("R1 irq", 32'(irq), 0);
    for (int r = 0; r < 5; r++) begin
      rd(4'(2 * r), d);
      check("R1 control reg zero", 32'(d), 0);
    end
    rd(4'hB, d);
    check("R1 no event", 32'(d), 0);
  endtask

  task automatic t_setclr();
    logic [N-1:0] d;
    wr(4'h2, 12'h0F3);
    rd(4'h2, d);
    check("R3 set", 32'(d), 32'(12'h0F3));
    wr(4'h2, 12'h800);
    wr(4'h3, 12'h003);
    rd(4'h2, d);
    check("R3 clear keeps others", 32'(d), 32'(12'h8F0));
    wr(4'hA, 12'hFFF);
    wr(4'hB, 12'hFFF);
    rd(4'h2, d);
    check("R12 read-only writes ignored dir", 32'(d), 32'(12'h8F0));
    rd(4'h0, d);
    check("R12 read-only writes ignored own", 32'(d), 0);
    wr(4'h3, 12'hFFF);
  endtask

  task automatic t_mux();
    logic [N-1:0] own_m = 12'h00F;
    logic [N-1:0] dir_m = 12'h005;
    logic [N-1:0] out_m = 12'h003;
    per_out = 12'hFF0; per_oe = 12'h0FF;
    wr(4'h0, own_m);
    wr(4'h2, dir_m);
    wr(4'h4, out_m);
    idle(2);
    check("R4 pad_oe owned", 32'(pad_oe), 32'((own_m & dir_m) | (~own_m & per_oe)));
    check("R4 pad_out owned", 32'(pad_out), 32'((own_m & out_m) | (~own_m & per_out)));
    per_out = 12'h0A0; per_oe = 12'hF00;
    idle(2);
    check("R2 peripheral pins follow", 32'(pad_out & ~own_m), 32'(12'h0A0 & ~own_m));
    check("R2 peripheral oe follow", 32'(pad_oe & ~own_m), 32'(12'hF00 & ~own_m));
    wr(4'h1, 12'hFFF);
    idle(2);
    check("R2 released pins follow peripheral", 32'(pad_oe), 32'(12'hF00));
  endtask

  task automatic t_level();
    logic [N-1:0] d;
    pad_in = 12'h5A3;
    idle(4);
    rd(4'hA, d);
    check("R5 pin level", 32'(d), 32'(12'h5A3));
    pad_in = 12'h000;
    idle(4);
    rd(4'hA, d);
    check("R5 pin level low", 32'(d), 0);
    idle(2);
    rd(4'hB, d);
  endtask

  task automatic t_change();
    logic [N-1:0] d;
    pad_in[3] = 1'b1;
    idle(5);
    rd(4'hB, d);
    check("R8 rising edge event", 32'(d), 32'(12'h008));
    rd(4'hB, d);
    check("R9 cleared after read", 32'(d), 0);
    pad_in[3] = 1'b0;
    idle(5);
    idle(3);
    rd(4'hB, d);
    check("R8 falling edge event, sticky", 32'(d), 32'(12'h008));
  endtask

  task automatic t_filter();
    logic [N-1:0] d;
    wr(4'h6, 12'h004);
    idle(3);
    rd(4'hB, d);
    @(negedge clk); pad_in[2] = 1'b1;
    @(negedge clk); pad_in[2] = 1'b0;
    idle(6);
    rd(4'hA, d);
    check("R6 short pulse level", 32'(d), 0);
    rd(4'hB, d);
    check("R6 short pulse no event", 32'(d), 0);
    @(negedge clk); pad_in[2] = 1'b1;
    idle(2);
    pad_in[2] = 1'b0;
    idle(6);
    rd(4'hB, d);
    check("R7 two-cycle pulse accepted", 32'(d), 32'(12'h004));
    wr(4'h7, 12'h004);
    idle(3);
    rd(4'hB, d);
    @(negedge clk); pad_in[2] = 1'b1;
    @(negedge clk); pad_in[2] = 1'b0;
    idle(6);
    rd(4'hB, d);
    check("R11 unfiltered pulse recorded", 32'(d), 32'(12'h004));
  endtask

  task automatic t_irq();
    logic [N-1:0] d;
    wr(4'h8, 12'h020);
    pad_in[4] = 1'b1;
    idle(6);
    check("R10 disabled pin no irq", 32'(irq), 0);
    pad_in[5] = 1'b1;
    idle(6);
    check("R10 enabled pin irq", 32'(irq), 1);
    rd(4'hB, d);
    check("R9 both events returned", 32'(d), 32'(12'h030));
    idle(2);
    check("R10 irq drops after clear", 32'(irq), 0);
    wr(4'h9, 12'h020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_setclr();
    t_mux();
    t_level();
    t_change();
    t_filter();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule